// File: doc/BRIEF.md
# Read-Modify-Write Reconfiguration Sequencer

This block changes selected bits of one register inside a remote transceiver reconfiguration controller without disturbing the other bits of that register. The controller is reached only indirectly. A small window of registers is exposed on a memory-mapped bus: a channel selector, a mode selector, an offset pointer, a data word and a command/status word. The sequencer is the bus master for that window. For each update it first fetches the current contents of the target register. It then merges in new bits under a mask and stores the merged word back.

A receiver-side client hands over one update at a time on a valid/ready request channel. The request carries the channel number, the register offset, the bit mask and the new bit values. `req_ready` is high only while the sequencer is idle. A request is taken on the rising edge where `req_valid` and `req_ready` are both high. A client that holds `req_valid` while the sequencer is busy waits: nothing is taken, and changing the request fields has no effect until `req_ready` returns. When the write-back has been confirmed, the sequencer pulses `done` for one clock and becomes ready again in the following cycle. The memory-mapped side follows the usual wait-state rule: a stalled access is held unchanged until the slave lowers `av_waitrequest`.

Top module: `rmw_reconfig_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `av_read`, `av_write` and `done` are low and `req_ready` is high.
- R2: Each accepted request begins with a write of the request channel (zero-extended) to word address 0, followed by a write of value 1 to word address 1.
- R3: The read phase writes the request offset (zero-extended) to address 2, then writes value 0x2 (go-read, bit 1) to address 4.
- R4: After go-read, the sequencer reads address 4 repeatedly while bit 8 (busy) of the returned word is 1. Other bits of that word are ignored. Only after a read of address 4 returns bit 8 = 0 does it read address 3 once.
- R5: The write phase writes the offset to address 2, then writes the merged word to address 3, then writes value 0x1 (go-write, bit 0) to address 4.
- R6: After go-write, the sequencer polls address 4 in the same way as in R4. `done` is high for exactly one clock, in the cycle after the poll that returns busy = 0. `req_ready` is high again in the cycle after that.
- R7: The merged word is (old & ~mask) | (value & mask), where old is the address-3 word read in R4. This holds for a mask of all zeros and a mask of all ones.
- R8: While `av_waitrequest` is high during an access, the address, the read and write strobes and the write data stay unchanged. `av_readdata` is used only in the cycle in which `av_waitrequest` is low.
- R9: `req_ready` is low from the cycle after acceptance until the cycle after `done`. A request offered in that interval causes no bus access and no change to any remote register.
- R10: At most one access is in progress at any time: `av_read` and `av_write` are never high together, and neither is high while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Client offers an update |
| req_ready | output | 1 | Sequencer idle; the offer is taken this cycle |
| req_channel | input | CHAN_W | Logical channel of the target |
| req_offset | input | OFS_W | Register offset inside the remote controller |
| req_mask | input | DATA_W | Bits to replace (1 = replace) |
| req_value | input | DATA_W | Replacement bit values |
| done | output | 1 | One-cycle completion pulse |
| av_address | output | ADDR_W | Word address in the register window |
| av_read | output | 1 | Read strobe |
| av_write | output | 1 | Write strobe |
| av_writedata | output | DATA_W | Write data |
| av_readdata | input | DATA_W | Read data, valid when waitrequest is low |
| av_waitrequest | input | 1 | Slave stall |

## Verification
Two events can fall in the same cycle: the one-cycle `done` pulse and a client offer that is already waiting. The offer must not be taken during the pulse. It must be taken only in the following idle cycle, and it must then see the register contents that the first update just wrote. The bench provokes this by keeping `req_valid` high through a whole update while it swaps the request fields to a second update on the same offset. Every clock it compares `done`, `req_ready` and each completed bus access against a behavioural model and a model of the remote slave. The slave inserts random wait states, and it returns a busy word on stalled reads, so any early sampling of the read data shows up as a mismatch.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CHAN,
    S_MODE,
    S_OFS_R,
    S_GO_R,
    S_POLL_R,
    S_DATA_R,
    S_OFS_W,
    S_DATA_W,
    S_GO_W,
    S_POLL_W,
    S_DONE
  } seq_state_t;

endpackage

// File: rtl/rmw_seq_fsm.sv
module rmw_seq_fsm
  import rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       step_done,
  input  logic       busy_seen,
  output seq_state_t state
);

  seq_state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:   if (start) nxt = S_CHAN;
      S_CHAN:   if (step_done) nxt = S_MODE;
      S_MODE:   if (step_done) nxt = S_OFS_R;
      S_OFS_R:  if (step_done) nxt = S_GO_R;
      S_GO_R:   if (step_done) nxt = S_POLL_R;
      S_POLL_R: if (step_done && !busy_seen) nxt = S_DATA_R;
      S_DATA_R: if (step_done) nxt = S_OFS_W;
      S_OFS_W:  if (step_done) nxt = S_DATA_W;
      S_DATA_W: if (step_done) nxt = S_GO_W;
      S_GO_W:   if (step_done) nxt = S_POLL_W;
      S_POLL_W: if (step_done && !busy_seen) nxt = S_DONE;
      S_DONE:   nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end

endmodule

// File: rtl/rmw_bus_drive.sv
module rmw_bus_drive
  import rmw_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int CHAN_W      = 8,
  parameter int OFS_W       = 12,
  parameter int A_CHAN      = 0,
  parameter int A_MODE      = 1,
  parameter int A_OFS       = 2,
  parameter int A_DATA      = 3,
  parameter int A_CSR       = 4,
  parameter int RD_GO_BIT   = 1,
  parameter int WR_GO_BIT   = 0,
  parameter int STREAM_MODE = 1
) (
  input  seq_state_t          state,
  input  logic [CHAN_W-1:0]   chan,
  input  logic [OFS_W-1:0]    ofs,
  input  logic [DATA_W-1:0]   merged,
  output logic [ADDR_W-1:0]   addr,
  output logic                rd,
  output logic                wr,
  output logic [DATA_W-1:0]   wdata
);

  localparam logic [DATA_W-1:0] CMD_RD   = DATA_W'(1) << RD_GO_BIT;
  localparam logic [DATA_W-1:0] CMD_WR   = DATA_W'(1) << WR_GO_BIT;
  localparam logic [DATA_W-1:0] MODE_VAL = DATA_W'(STREAM_MODE);

  always_comb begin
    addr  = '0;
    rd    = 1'b0;
    wr    = 1'b0;
    wdata = '0;
    case (state)
      S_CHAN: begin
        wr = 1'b1; addr = ADDR_W'(A_CHAN); wdata = DATA_W'(chan);
      end
      S_MODE: begin
        wr = 1'b1; addr = ADDR_W'(A_MODE); wdata = MODE_VAL;
      end
      S_OFS_R, S_OFS_W: begin
        wr = 1'b1; addr = ADDR_W'(A_OFS); wdata = DATA_W'(ofs);
      end
      S_GO_R: begin
        wr = 1'b1; addr = ADDR_W'(A_CSR); wdata = CMD_RD;
      end
      S_POLL_R, S_POLL_W: begin
        rd = 1'b1; addr = ADDR_W'(A_CSR);
      end
      S_DATA_R: begin
        rd = 1'b1; addr = ADDR_W'(A_DATA);
      end
      S_DATA_W: begin
        wr = 1'b1; addr = ADDR_W'(A_DATA); wdata = merged;
      end
      S_GO_W: begin
        wr = 1'b1; addr = ADDR_W'(A_CSR); wdata = CMD_WR;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rmw_merge.sv
module rmw_merge #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] merged
);

  logic [DATA_W-1:0] old_q;

  always_ff @(posedge clk) begin
    if (rst)       old_q <= '0;
    else if (load) old_q <= rdata;
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign merged[b] = mask[b] ? value[b] : old_q[b];
  end

endmodule

// File: rtl/rmw_reconfig_seq.sv
module rmw_reconfig_seq
  import rmw_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int CHAN_W      = 8,
  parameter int OFS_W       = 12,
  parameter int A_CHAN      = 0,
  parameter int A_MODE      = 1,
  parameter int A_OFS       = 2,
  parameter int A_DATA      = 3,
  parameter int A_CSR       = 4,
  parameter int BUSY_BIT    = 8,
  parameter int RD_GO_BIT   = 1,
  parameter int WR_GO_BIT   = 0,
  parameter int STREAM_MODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CHAN_W-1:0] req_channel,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_mask,
  input  logic [DATA_W-1:0] req_value,
  output logic              done,
  output logic [ADDR_W-1:0] av_address,
  output logic              av_read,
  output logic              av_write,
  output logic [DATA_W-1:0] av_writedata,
  input  logic [DATA_W-1:0] av_readdata,
  input  logic              av_waitrequest
);

  seq_state_t        state;
  logic              accept;
  logic              step_done;
  logic              capture;
  logic [CHAN_W-1:0] chan_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] value_q;
  logic [DATA_W-1:0] merged;

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign done      = (state == S_DONE);
  assign step_done = (av_read || av_write) && !av_waitrequest;
  assign capture   = (state == S_DATA_R) && step_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q  <= '0;
      ofs_q   <= '0;
      mask_q  <= '0;
      value_q <= '0;
    end else if (accept) begin
      chan_q  <= req_channel;
      ofs_q   <= req_offset;
      mask_q  <= req_mask;
      value_q <= req_value;
    end
  end

  rmw_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .step_done (step_done),
    .busy_seen (av_readdata[BUSY_BIT]),
    .state     (state)
  );

  rmw_merge #(.DATA_W(DATA_W)) u_merge (
    .clk    (clk),
    .rst    (rst),
    .load   (capture),
    .rdata  (av_readdata),
    .mask   (mask_q),
    .value  (value_q),
    .merged (merged)
  );

  rmw_bus_drive #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .OFS_W(OFS_W),
    .A_CHAN(A_CHAN), .A_MODE(A_MODE), .A_OFS(A_OFS), .A_DATA(A_DATA),
    .A_CSR(A_CSR), .RD_GO_BIT(RD_GO_BIT), .WR_GO_BIT(WR_GO_BIT),
    .STREAM_MODE(STREAM_MODE)
  ) u_drive (
    .state  (state),
    .chan   (chan_q),
    .ofs    (ofs_q),
    .merged (merged),
    .addr   (av_address),
    .rd     (av_read),
    .wr     (av_write),
    .wdata  (av_writedata)
  );

endmodule

// File: rtl/rmw_seq_chk.sv
module rmw_seq_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int A_CSR    = 4,
  parameter int BUSY_BIT = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic [ADDR_W-1:0] av_address,
  input logic              av_read,
  input logic              av_write,
  input logic [DATA_W-1:0] av_writedata,
  input logic [DATA_W-1:0] av_readdata,
  input logic              av_waitrequest
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!av_read && !av_write && !done && req_ready)); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((av_read || av_write) && av_waitrequest) |=>
      ($stable(av_address) && $stable(av_read) && $stable(av_write) && $stable(av_writedata))); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_DONE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(av_read && !av_waitrequest && (av_address == ADDR_W'(A_CSR))
                   && !av_readdata[BUSY_BIT])); // R6

  AST_TAKE_THEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R9

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(av_read && av_write)); // R10

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!av_read && !av_write)); // R10

endmodule

bind rmw_reconfig_seq rmw_seq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .A_CSR(A_CSR), .BUSY_BIT(BUSY_BIT)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .done           (done),
  .av_address     (av_address),
  .av_read        (av_read),
  .av_write       (av_write),
  .av_writedata   (av_writedata),
  .av_readdata    (av_readdata),
  .av_waitrequest (av_waitrequest)
);

// File: tb/test_rmw_reconfig_seq.sv
`timescale 1ns/1ps
module test_rmw_reconfig_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_channel = '0;
  logic [11:0] req_offset = '0;
  logic [31:0] req_mask = '0;
  logic [31:0] req_value = '0;
  logic        done;
  logic [2:0]  av_address;
  logic        av_read;
  logic        av_write;
  logic [31:0] av_writedata;
  logic [31:0] av_readdata = '0;
  logic        av_waitrequest = 1'b0;

  always #2.5 clk = ~clk;

  rmw_reconfig_seq i_rmw_reconfig_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_channel(req_channel), .req_offset(req_offset), .req_mask(req_mask),
    .req_value(req_value), .done(done), .av_address(av_address),
    .av_read(av_read), .av_write(av_write), .av_writedata(av_writedata),
    .av_readdata(av_readdata), .av_waitrequest(av_waitrequest)
  );

  typedef struct {
    bit          wr;
    logic [2:0]  a;
    logic [31:0] d;
    string       tag;
  } xact_t;

  xact_t       exq[$];
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;
  logic [31:0] mem [16];
  logic [31:0] exp_mem [16];
  logic [3:0]  s_ofs = '0;
  logic [31:0] s_data = '0;
  int          busy_cnt = 0;
  int          busy1 = 0;
  int          busy2 = 0;
  bit          wait_on = 0;
  logic [15:0] lf = 16'hACE1;
  bit          ready_nxt = 1;
  bit          done_nxt = 0;
  bit          exp_ready = 1;
  bit          exp_done = 0;
  bit          stalled = 0;
  logic [2:0]  h_addr;
  logic        h_rd, h_wr;
  logic [31:0] h_wd;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic push_req();
    logic [31:0] old, mrg;
    old = exp_mem[req_offset[3:0]];
    mrg = (old & ~req_mask) | (req_value & req_mask);
    exp_mem[req_offset[3:0]] = mrg;
    exq.push_back('{1'b1, 3'd0, 32'(req_channel), "R2"});
    exq.push_back('{1'b1, 3'd1, 32'd1, "R2"});
    exq.push_back('{1'b1, 3'd2, 32'(req_offset), "R3"});
    exq.push_back('{1'b1, 3'd4, 32'h2, "R3"});
    for (int i = 0; i <= busy1; i++) exq.push_back('{1'b0, 3'd4, 32'h0, "R4"});
    exq.push_back('{1'b0, 3'd3, 32'h0, "R4"});
    exq.push_back('{1'b1, 3'd2, 32'(req_offset), "R5"});
    exq.push_back('{1'b1, 3'd3, mrg, "R7"});
    exq.push_back('{1'b1, 3'd4, 32'h1, "R5"});
    for (int i = 0; i <= busy2; i++) exq.push_back('{1'b0, 3'd4, 32'h0, "R6"});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Reference model of sequencer handshake and remote slave, evaluated every clock
  always @(negedge clk) begin
    if (!rst) begin
      exp_ready = ready_nxt;
      exp_done  = done_nxt;
      done_nxt  = 0;
      if (exp_done) ready_nxt = 1;
      chk(done == exp_done, "R6", "done", 32'(done), 32'(exp_done));
      chk(req_ready == exp_ready, "R9", "req_ready", 32'(req_ready), 32'(exp_ready));
      chk(!(av_read && av_write), "R10", "rd&wr", 32'({av_read, av_write}), 32'h0);
      if (stalled)
        chk(av_address == h_addr && av_read == h_rd && av_write == h_wr && av_writedata == h_wd,
            "R8", "held access", {av_read, av_write, av_address, av_writedata[26:0]},
            {h_rd, h_wr, h_addr, h_wd[26:0]});
      if (req_valid && req_ready) begin
        push_req();
        ready_nxt = 0;
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      av_waitrequest = wait_on && lf[0];
      av_readdata = 32'hFFFF_FFFF;
      stalled = (av_read || av_write) && av_waitrequest;
      h_addr = av_address; h_rd = av_read; h_wr = av_write; h_wd = av_writedata;
      if ((av_read || av_write) && !av_waitrequest) begin
        if (exq.size() == 0) begin
          chk(0, "R10", "unexpected access addr", 32'(av_address), 32'hFFFF_FFFF);
        end else begin
          xact_t e;
          e = exq.pop_front();
          chk(av_write == e.wr && av_address == e.a, e.tag, "access kind/addr",
              32'({av_write, av_address}), 32'({e.wr, e.a}));
          if (e.wr) chk(av_writedata == e.d, e.tag, "write data", av_writedata, e.d);
          if (av_write) begin
            case (av_address)
              3'd2: s_ofs = av_writedata[3:0];
              3'd3: s_data = av_writedata;
              3'd4: begin
                if (av_writedata[1]) begin s_data = mem[s_ofs]; busy_cnt = busy1; end
                else if (av_writedata[0]) begin mem[s_ofs] = s_data; busy_cnt = busy2; end
              end
              default: ;
            endcase
          end else begin
            if (av_address == 3'd4) begin
              av_readdata = 32'h0000_00F0 | ((busy_cnt > 0) ? 32'h100 : 32'h0);
              if (busy_cnt > 0) busy_cnt--;
            end else if (av_address == 3'd3) begin
              av_readdata = s_data;
            end
          end
          if (exq.size() == 0) done_nxt = 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL R6 watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  task automatic wait_done(input string tag);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 3000);
    chk(done == 1'b1, tag, "completion seen", 32'(done), 32'h1);
  endtask

  task automatic offer(input logic [7:0] ch, input logic [11:0] ofs,
                       input logic [31:0] m, input logic [31:0] v);
    @(posedge clk); #1;
    req_channel = ch; req_offset = ofs; req_mask = m; req_value = v;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic one_update(input logic [7:0] ch, input logic [11:0] ofs,
                            input logic [31:0] m, input logic [31:0] v,
                            input int b1, input int b2, input bit w, input string tag);
    busy1 = b1; busy2 = b2; wait_on = w;
    offer(ch, ofs, m, v);
    wait_done("R6");
    @(negedge clk);
    chk(mem[ofs[3:0]] == exp_mem[ofs[3:0]], tag, "remote register",
        mem[ofs[3:0]], exp_mem[ofs[3:0]]);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h5A5A_0000 ^ (32'(i) * 32'h0101_0101);
      exp_mem[i] = mem[i];
    end
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet outputs while in reset
    chk(!av_read && !av_write, "R1", "strobes in reset", 32'({av_read, av_write}), 32'h0);
    chk(done == 1'b0, "R1", "done in reset", 32'(done), 32'h0);
    chk(req_ready == 1'b1, "R1", "ready in reset", 32'(req_ready), 32'h1);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(!av_read && !av_write && req_ready, "R1", "idle after reset",
        32'({av_read, av_write, req_ready}), 32'h1);

    // Basic update, no stalls, no busy polls (R2 R3 R4 R5 R6 R7)
    one_update(8'h05, 12'd3, 32'h0000_FF00, 32'h1234_5678, 0, 0, 0, "R7");
    // Busy polls and random wait states (R4 R6 R8)
    one_update(8'h2A, 12'd7, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 3, 2, 1, "R4");
    // Mask corners (R7)
    one_update(8'h81, 12'd1, 32'hFFFF_FFFF, 32'hCAFE_BABE, 1, 1, 1, "R7");
    one_update(8'h11, 12'd2, 32'h0000_0000, 32'hFFFF_FFFF, 2, 0, 1, "R7");

    // R9: an offer while busy is ignored
    busy1 = 4; busy2 = 4; wait_on = 1;
    offer(8'h33, 12'd4, 32'h00FF_0000, 32'h0077_0000);
    repeat (6) @(posedge clk);
    #1;
    req_channel = 8'hEE; req_offset = 12'd9; req_mask = 32'hFFFF_FFFF; req_value = 32'h0;
    req_valid = 1'b1;
    repeat (5) @(posedge clk);
    #1 req_valid = 1'b0;
    wait_done("R9");
    @(negedge clk);
    chk(mem[4] == exp_mem[4], "R9", "accepted update", mem[4], exp_mem[4]);
    chk(mem[9] == 32'h5A5A_0000 ^ (32'd9 * 32'h0101_0101), "R9", "ignored offset",
        mem[9], 32'h5A5A_0000 ^ (32'd9 * 32'h0101_0101));

    // Back-to-back: second offer waits through done, then sees first result (R6 R7 R9)
    busy1 = 1; busy2 = 2; wait_on = 1;
    @(posedge clk); #1;
    req_channel = 8'h07; req_offset = 12'd5; req_mask = 32'h0000_00FF; req_value = 32'h0000_00AB;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_mask = 32'h0000_FF00; req_value = 32'h0000_CD00;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1 req_valid = 1'b0;
    wait_done("R6");
    @(negedge clk);
    chk(mem[5] == exp_mem[5], "R7", "chained merge", mem[5], exp_mem[5]);
    chk(exq.size() == 0, "R6", "no pending accesses", 32'(exq.size()), 32'h0);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule